// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Request-to-Send and Break

This block turns parallel characters into an asynchronous serial stream on a single line. A character written into its one-entry holding buffer goes out as a start bit, five to eight data bits least significant first, an optional parity bit and one or two stop bits. Every bit lasts one bit period, which is paced by a single-cycle bit-rate enable from an external rate generator. When a new character is already waiting as the last stop bit ends, the next start bit follows at once with no idle period in between.

The block also drives an active-low request-to-send output. It asserts as soon as its control bit is set. When the control bit is cleared, release is held back until the line has fully drained: one bit period after the final stop bit, and only if no character is still waiting. A send-break control forces the line low whether or not the transmitter is enabled. With the break control cleared and nothing to send, the line rests high.

Top module: `async_tx`

## Requirements
- R1: After reset `txd` is 1, `rts_n` is 1 and `buf_empty` is 1.
- R2: A frame is a 0 start bit, then `5 + char_len` data bits (char_len 0..3 gives 5..8 bits) least significant bit first, then parity if enabled, then stop bits of value 1. Each bit lasts from one `bit_tick` to the next. A frame starts at the first `bit_tick` at which a character is waiting and `tx_en` is 1.
- R3: With `par_en` = 1, the parity bit is the XOR of the sent data bits when `par_odd` = 0, and its inverse when `par_odd` = 1.
- R4: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R5: A write through `wr_stb` makes `buf_empty` 0 from the next cycle. A character waiting when a stop period ends starts at that same tick with no idle bit. A write in the very cycle the buffer is taken is kept as the next character.
- R6: While `tx_en` is 0 no new frame starts: `txd` stays 1 and a written character stays in the buffer (`buf_empty` = 0).
- R7: `brk_ctl` = 1 drives `txd` to 0 from the next cycle, even with `tx_en` = 0. Clearing it gives the line back to the transmitter one cycle later.
- R8: `rts_ctl` = 1 drives `rts_n` to 0 from the next cycle.
- R9: After `rts_ctl` is cleared, `rts_n` rises only one bit period after the tick that ends the last stop bit, and only if no character is waiting or sending. A character still buffered keeps `rts_n` low until that character is also out.
- R10: With `brk_ctl` = 0 and no frame in progress, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| wr_stb | input | 1 | Load `wr_data` into the holding buffer |
| wr_data | input | 8 | Character to send |
| tx_en | input | 1 | Transmitter enable |
| rts_ctl | input | 1 | Request-to-send control bit |
| brk_ctl | input | 1 | Send-break control bit |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| txd | output | 1 | Serial data line, idle high |
| rts_n | output | 1 | Request-to-send, active low |
| buf_empty | output | 1 | Holding buffer empty flag |

## Verification
Two things can fall on the same cycle here: the shifter taking the waiting character at the end of a stop bit, and a new write into the holding buffer. The bench writes a third character exactly on the tick at which the second one is taken. It then expects the three frames to run back to back, with no lost or repeated character and no idle bit between them. In the same run, request-to-send is cleared while the buffer is still full, and `rts_n` is checked to stay low until one bit period after the third frame's stop bit.

// File: rtl/atx_pkg.sv
package atx_pkg;

    parameter int DATA_W   = 8;
    parameter int MIN_BITS = 5;
    parameter int STOP_MAX = 2;
    parameter int LEN_W    = 2;

    localparam int FRAME_W = 1 + DATA_W + 1 + STOP_MAX;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } fmt_t;

    // Whole frame, LSB goes out first; unused upper positions are marking.
    function automatic logic [FRAME_W-1:0] frame_bits(logic [DATA_W-1:0] d, fmt_t f);
        logic [FRAME_W-1:0] fr;
        logic               p;
        int                 n;
        n  = MIN_BITS + int'(f.len);
        fr = '1;
        fr[0] = 1'b0;
        p  = f.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) begin
                fr[i+1] = d[i];
                p       = p ^ d[i];
            end
        end
        if (f.par_en) fr[n+1] = p;
        return fr;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(fmt_t f);
        int n;
        n = 2 + MIN_BITS + int'(f.len) + int'(f.par_en) + int'(f.two_stop);
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/atx_buffer.sv
module atx_buffer
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_stb) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              full,
    input  logic [DATA_W-1:0] data,
    input  fmt_t              fmt,
    output logic              take,
    output logic              busy,
    output logic              ending,
    output logic              line
);
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic               last_bit;
    logic               start_ok;

    assign last_bit = busy && (cnt == CNT_W'(1));
    assign start_ok = full && en;
    assign take     = tick && start_ok && (!busy || last_bit);
    assign ending   = tick && last_bit && !start_ok;
    assign line     = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (take) begin
            sh   <= frame_bits(data, fmt);
            cnt  <= frame_len(fmt);
            busy <= 1'b1;
        end else if (tick && busy) begin
            if (last_bit) begin
                busy <= 1'b0;
            end else begin
                sh  <= {1'b1, sh[FRAME_W-1:1]};
                cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/atx_rts.sv
module atx_rts (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rts_ctl,
    input  logic ending,
    input  logic busy,
    input  logic full,
    output logic rts_n
);
    logic act;
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            pend <= 1'b0;
        end else if (rts_ctl) begin
            act  <= 1'b1;
            pend <= 1'b0;
        end else if (act && tick) begin
            if (pend) begin
                if (!busy && !full) act <= 1'b0;
                pend <= 1'b0;
            end else if ((ending || !busy) && !full) begin
                pend <= 1'b1;
            end
        end
    end

    assign rts_n = !act;
endmodule

// File: rtl/async_tx.sv
module async_tx
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              rts_ctl,
    input  logic              brk_ctl,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              txd,
    output logic              rts_n,
    output logic              buf_empty
);
    fmt_t              fmt;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_take;
    logic              sh_busy;
    logic              sh_ending;
    logic              sh_line;
    logic              txd_q;

    assign fmt = '{len: char_len, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    atx_buffer u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (sh_take),
        .full    (hold_full),
        .data    (hold_data)
    );

    atx_shifter u_shf (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_tick),
        .en     (tx_en),
        .full   (hold_full),
        .data   (hold_data),
        .fmt    (fmt),
        .take   (sh_take),
        .busy   (sh_busy),
        .ending (sh_ending),
        .line   (sh_line)
    );

    atx_rts u_rts (
        .clk     (clk),
        .rst     (rst),
        .tick    (bit_tick),
        .rts_ctl (rts_ctl),
        .ending  (sh_ending),
        .busy    (sh_busy),
        .full    (hold_full),
        .rts_n   (rts_n)
    );

    always_ff @(posedge clk) begin
        if (rst) txd_q <= 1'b1;
        else     txd_q <= brk_ctl ? 1'b0 : sh_line;
    end

    assign txd       = txd_q;
    assign buf_empty = !hold_full;
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic tx_en,
    input logic rts_ctl,
    input logic brk_ctl,
    input logic txd,
    input logic rts_n,
    input logic buf_empty,
    input logic busy
);
    a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
        brk_ctl |=> !txd);

    a_r8_rts_assert: assert property (@(posedge clk) disable iff (rst)
        rts_ctl |=> !rts_n);

    a_r10_idle_mark: assert property (@(posedge clk) disable iff (rst)
        (!brk_ctl && !busy) |=> txd);

    a_r5_write_fills: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !buf_empty);

    a_r6_start_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tx_en));

    a_r9_release_drained: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_n) |-> ($past(buf_empty) && !$past(busy) && !$past(rts_ctl)));
endmodule

bind async_tx atx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .tx_en     (tx_en),
    .rts_ctl   (rts_ctl),
    .brk_ctl   (brk_ctl),
    .txd       (txd),
    .rts_n     (rts_n),
    .buf_empty (buf_empty),
    .busy      (sh_busy)
);

// File: tb/tb_async_tx.sv
module tb_async_tx;
    logic       clk = 1'b0;
    logic       rst;
    logic       bit_tick;
    logic [1:0] tcnt;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       tx_en, rts_ctl, brk_ctl;
    logic [1:0] char_len;
    logic       par_en, par_odd, two_stop;
    logic       txd, rts_n, buf_empty;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt     <= '0;
            bit_tick <= 1'b0;
        end else begin
            tcnt     <= tcnt + 2'd1;
            bit_tick <= (tcnt == 2'd3);
        end
    end

    async_tx dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_data(wr_data),
        .tx_en(tx_en), .rts_ctl(rts_ctl), .brk_ctl(brk_ctl), .char_len(char_len),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .txd(txd), .rts_n(rts_n), .buf_empty(buf_empty)
    );

    // {data, len, par_en, par_odd, two_stop}
    localparam logic [12:0] VEC [8] = '{
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
        {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0},
        {8'h3C, 2'd3, 1'b1, 1'b1, 1'b1},
        {8'hFF, 2'd0, 1'b0, 1'b0, 1'b1},
        {8'h15, 2'd0, 1'b1, 1'b1, 1'b0},
        {8'h2A, 2'd1, 1'b1, 1'b0, 1'b1},
        {8'h55, 2'd2, 1'b1, 1'b1, 1'b0},
        {8'h00, 2'd2, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_frame(input logic [7:0] d, input logic [1:0] l, input logic pe,
                                     input logic po, input logic ts, output logic [11:0] fr);
        int k = 1;
        logic p = po;
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < 5 + int'(l); i++) begin
            fr[k] = d[i];
            p = p ^ d[i];
            k++;
        end
        if (pe) begin
            fr[k] = p;
            k++;
        end
        return k + 1 + int'(ts);
    endfunction

    task automatic next_tick();
        forever begin
            @(negedge clk);
            if (bit_tick) break;
        end
    endtask

    task automatic capture(input int n, output logic [35:0] v);
        v = '1;
        for (int g = 0; g < 4000; g++) begin
            @(negedge clk);
            if (bit_tick && !txd) break;
        end
        v[0] = txd;
        for (int i = 1; i < n; i++) begin
            next_tick();
            v[i] = txd;
        end
    endtask

    task automatic set_fmt(input logic [1:0] l, input logic pe, input logic po, input logic ts);
        char_len = l; par_en = pe; par_odd = po; two_stop = ts;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] fr, fr2, fr3;
        logic [35:0] got, exp;
        int n;
        bit ok;
        rst = 1'b1; wr_stb = 1'b0; wr_data = '0; tx_en = 1'b1;
        rts_ctl = 1'b0; brk_ctl = 1'b0;
        set_fmt(2'd3, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd === 1'b1, "R1 txd", 36'(txd), 36'd1);
        check(rts_n === 1'b1, "R1 rts_n", 36'(rts_n), 36'd1);
        check(buf_empty === 1'b1, "R1 buf_empty", 36'(buf_empty), 36'd1);
        rst = 1'b0;
        repeat (6) @(negedge clk);

        // R2 R3 R4 frame vectors
        for (int t = 0; t < 8; t++) begin
            set_fmt(VEC[t][4:3], VEC[t][2], VEC[t][1], VEC[t][0]);
            n = exp_frame(VEC[t][12:5], VEC[t][4:3], VEC[t][2], VEC[t][1], VEC[t][0], fr);
            write(VEC[t][12:5]);
            capture(n, got);
            exp = '1; exp[11:0] = fr;
            got[35:12] = '1;
            check(got === exp, "R2 R3 R4 frame", got, exp);
            next_tick(); next_tick();
            // R10 idle line marking
            check(txd === 1'b1, "R10 idle txd", 36'(txd), 36'd1);
        end

        // R6 disabled transmitter holds char
        tx_en = 1'b0;
        set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
        write(8'h00);
        ok = 1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) ok = 0;
        end
        check(ok, "R6 txd stays marking", 36'(!ok), 36'd0);
        check(buf_empty === 1'b0, "R6 buffer holds", 36'(buf_empty), 36'd0);
        // R7 break while disabled
        brk_ctl = 1'b1;
        @(negedge clk); @(negedge clk);
        check(txd === 1'b0, "R7 break low", 36'(txd), 36'd0);
        brk_ctl = 1'b0;
        @(negedge clk); @(negedge clk);
        check(txd === 1'b1, "R7 break release", 36'(txd), 36'd1);
        n = exp_frame(8'h00, 2'd3, 1'b1, 1'b0, 1'b0, fr);
        tx_en = 1'b1;
        capture(n, got);
        exp = '1; exp[11:0] = fr; got[35:12] = '1;
        check(got === exp, "R6 frame after enable", got, exp);
        next_tick(); next_tick();

        // R8 R9 idle release
        rts_ctl = 1'b1;
        @(negedge clk); @(negedge clk);
        check(rts_n === 1'b0, "R8 rts asserted", 36'(rts_n), 36'd0);
        rts_ctl = 1'b0;
        next_tick(); next_tick(); next_tick();
        check(rts_n === 1'b1, "R9 idle release", 36'(rts_n), 36'd1);

        // R5 R9 three back-to-back characters, write on the take tick
        set_fmt(2'd1, 1'b1, 1'b1, 1'b0);
        n = exp_frame(8'h11, 2'd1, 1'b1, 1'b1, 1'b0, fr);
        void'(exp_frame(8'h2E, 2'd1, 1'b1, 1'b1, 1'b0, fr2));
        void'(exp_frame(8'h33, 2'd1, 1'b1, 1'b1, 1'b0, fr3));
        rts_ctl = 1'b1;
        @(negedge clk);
        fork
            capture(3 * n, got);
            begin
                write(8'h11);
                for (int g = 0; g < 4000; g++) begin
                    @(negedge clk);
                    if (bit_tick && !txd) break;
                end
                @(negedge clk);
                wr_stb = 1'b1; wr_data = 8'h2E;
                @(negedge clk);
                wr_stb = 1'b0;
                rts_ctl = 1'b0;
                for (int i = 1; i < n; i++) next_tick();
                wr_stb = 1'b1; wr_data = 8'h33;
                @(negedge clk);
                wr_stb = 1'b0;
                check(buf_empty === 1'b0, "R5 write on take kept", 36'(buf_empty), 36'd0);
            end
        join
        exp = '1;
        for (int i = 0; i < n; i++) begin
            exp[i]       = fr[i];
            exp[i + n]   = fr2[i];
            exp[i + 2*n] = fr3[i];
        end
        check(got === exp, "R5 back-to-back frames", got, exp);
        check(rts_n === 1'b0, "R9 low at last stop", 36'(rts_n), 36'd0);
        next_tick();
        check(rts_n === 1'b0, "R9 low one bit after", 36'(rts_n), 36'd0);
        @(negedge clk);
        check(rts_n === 1'b1, "R9 released", 36'(rts_n), 36'd1);
        check(buf_empty === 1'b1, "R5 drained", 36'(buf_empty), 36'd1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule